// File: doc/BRIEF.md
# Stop-State Oscillator Request Arbiter

While the chip sits in its stop state, every core-domain clock is halted and every oscillator is off. Some serial peripherals can still listen on their lines in this state. When one of them sees the start of traffic, it asks for the internal 16 MHz oscillator so that it can receive a whole frame. This block grants those requests. It switches the oscillator on and passes its clock only to the peripherals that asked for it. Once a peripheral signals the end of a frame, the block does one of two things. If the frame is not a wake-up frame, it releases that peripheral and stops the oscillator once no request is left. If the frame is a wake-up frame, it latches a system wake signal.

Five request sources are supported by default: two I2C controllers, two USARTs and one low-power UART. Each source has its own state machine with four states:
- `S_IDLE`: no clock.
- `S_WAIT_RDY`: the oscillator is enabled and the source waits for it to become stable.
- `S_ACTIVE`: the gate is open.
- `S_WAKE_HOLD`: a wake frame was received, and the gate stays open until stop exit.

Each source state machine has six transitions:
- `T_REQ`: IDLE to WAIT_RDY, taken when the request is seen during stop.
- `T_RDY`: WAIT_RDY to ACTIVE, taken when the oscillator ready input is seen.
- `T_DROP`: WAIT_RDY or ACTIVE to IDLE, taken when the request is withdrawn.
- `T_FRAME`: ACTIVE to IDLE, taken on frame done with the wake flag low.
- `T_WAKE`: ACTIVE to WAKE_HOLD, taken on frame done with the wake flag high.
- `T_EXIT`: any state to IDLE, taken when stop is left.

The oscillator enable is the OR of all sources that are not idle. Memory, register contents and pin levels are untouched by this block. It only drives clock enables.

Top module: `stop_clk_arbiter`

## Requirements
- R1: After reset, `osc_en`, every bit of `clk_gate_en` and `sys_wake` are 0.
- R2: While `stop_mode` is 1, a source in IDLE with its request bit at 1 moves to WAIT_RDY at the next edge. `osc_en` is 1 from that edge onward. `osc_en` is 1 exactly when at least one source is not idle.
- R3: A source's gate bit goes from 0 to 1 only at an edge where `osc_ready` was sampled 1 while that source was in WAIT_RDY. While `osc_ready` stays 0, no gate opens.
- R4: Bit i of `clk_gate_en` is 1 only for a source i that requested the clock. The gate bits of all other sources stay 0.
- R5: When `src_frame_done[i]` is 1 and `src_wake_frame[i]` is 0 while source i is ACTIVE, the gate of source i closes at the next edge. `osc_en` falls at that same edge if no other source is still busy.
- R6: When `src_frame_done[i]` and `src_wake_frame[i]` are both 1 while source i is ACTIVE, `sys_wake` is 1 from the next edge onward. It stays 1 until stop exit. Source i keeps its gate open and `osc_en` stays 1 until then.
- R7: When `stop_mode` is 0, all sources return to IDLE at the next edge, and `osc_en`, `clk_gate_en` and `sys_wake` are then 0. Requests made outside stop are ignored.
- R8: If a source's request falls to 0 while it is in WAIT_RDY or ACTIVE, with no frame done, the source goes to IDLE at the next edge and its gate closes.
- R9: A frame-done pulse from a source that is not ACTIVE has no effect. A waiting source stays waiting, and no gate opens and no wake is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on low-rate clock for the arbiter |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_mode | input | 1 | 1 while the system is in the stop state |
| osc_ready | input | 1 | Oscillator stable indication |
| src_req | input | 5 | Per-source clock request (bit order: I2C a, I2C b, USART a, USART b, LP UART) |
| src_frame_done | input | 5 | Per-source end-of-frame pulse |
| src_wake_frame | input | 5 | Per-source flag: the finished frame is a wake-up frame (valid with frame done) |
| osc_en | output | 1 | Oscillator enable |
| clk_gate_en | output | 5 | Per-source oscillator clock gate enable |
| sys_wake | output | 1 | Latched system wake request |

## Verification
Every result of this block lands exactly one edge after the input that causes it:
- `osc_en` one edge after a request.
- A gate bit one edge after ready is sampled.
- Gate release and `sys_wake` one edge after frame done.
- All clearing one edge after stop exit.

The bench drives inputs shortly after a rising edge and compares outputs 2 ns after the following edge. Each check therefore looks at the state that the single registered stage produced. All 32 request masks are swept, each paired with a computed wake subset. The expected gate, oscillator and wake values follow arithmetically from the mask and that subset.

// File: rtl/stop_arb_pkg.sv
package stop_arb_pkg;
    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_WAIT_RDY  = 2'd1,
        S_ACTIVE    = 2'd2,
        S_WAKE_HOLD = 2'd3
    } src_state_e;
endpackage

// File: rtl/stop_src_fsm.sv
module stop_src_fsm
    import stop_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_mode,
    input  logic osc_ready,
    input  logic req,
    input  logic frame_done,
    input  logic wake_frame,
    output logic busy,
    output logic gate_en,
    output logic wake_evt
);
    src_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!stop_mode) begin
            state_d = S_IDLE;                                  // T_EXIT
        end else begin
            unique case (state_q)
                S_IDLE:      if (req) state_d = S_WAIT_RDY;    // T_REQ
                S_WAIT_RDY: begin
                    if (!req)           state_d = S_IDLE;      // T_DROP
                    else if (osc_ready) state_d = S_ACTIVE;    // T_RDY
                end
                S_ACTIVE: begin
                    if (frame_done)
                        state_d = wake_frame ? S_WAKE_HOLD     // T_WAKE
                                             : S_IDLE;         // T_FRAME
                    else if (!req)
                        state_d = S_IDLE;                      // T_DROP
                end
                S_WAKE_HOLD: state_d = S_WAKE_HOLD;
                default:     state_d = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        gate_en  = (state_q == S_ACTIVE) || (state_q == S_WAKE_HOLD);
        wake_evt = stop_mode && (state_q == S_ACTIVE) && frame_done && wake_frame;
    end

    assert_gate_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(osc_ready) && $past(state_q == S_WAIT_RDY));

    assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAKE_HOLD && stop_mode) |=> (state_q == S_WAKE_HOLD));

    assert_exit_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |=> (state_q == S_IDLE));
endmodule

// File: rtl/stop_osc_ctrl.sv
module stop_osc_ctrl #(
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_mode,
    input  logic [N_SRC-1:0] busy,
    input  logic [N_SRC-1:0] gates,
    input  logic [N_SRC-1:0] wake_evt,
    output logic             osc_en,
    output logic             sys_wake
);
    logic wake_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wake_q <= 1'b0;
        else if (!stop_mode) wake_q <= 1'b0;
        else if (|wake_evt)  wake_q <= 1'b1;
    end

    always_comb begin
        osc_en   = |busy;
        sys_wake = wake_q;
    end

    assert_gate_needs_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|gates) |-> osc_en);

    assert_wake_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_wake && stop_mode) |=> sys_wake);

    assert_wake_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |=> !sys_wake);
endmodule

// File: rtl/stop_clk_arbiter.sv
module stop_clk_arbiter #(
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_mode,
    input  logic             osc_ready,
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] src_frame_done,
    input  logic [N_SRC-1:0] src_wake_frame,
    output logic             osc_en,
    output logic [N_SRC-1:0] clk_gate_en,
    output logic             sys_wake
);
    logic [N_SRC-1:0] busy;
    logic [N_SRC-1:0] wake_evt;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        stop_src_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .stop_mode  (stop_mode),
            .osc_ready  (osc_ready),
            .req        (src_req[i]),
            .frame_done (src_frame_done[i]),
            .wake_frame (src_wake_frame[i]),
            .busy       (busy[i]),
            .gate_en    (clk_gate_en[i]),
            .wake_evt   (wake_evt[i])
        );
    end

    stop_osc_ctrl #(.N_SRC(N_SRC)) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_mode (stop_mode),
        .busy      (busy),
        .gates     (clk_gate_en),
        .wake_evt  (wake_evt),
        .osc_en    (osc_en),
        .sys_wake  (sys_wake)
    );

    assert_gate_only_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_gate_en[0]) |-> $past(src_req[0]));

    assert_no_gate_outside_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |=> (clk_gate_en == '0) && !osc_en);
endmodule

// File: tb/test_stop_clk_arbiter.sv
module test_stop_clk_arbiter;
    localparam int N = 5;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_mode = 1'b0, osc_ready = 1'b0;
    logic [N-1:0] src_req = '0, src_frame_done = '0, src_wake_frame = '0;
    logic osc_en, sys_wake;
    logic [N-1:0] clk_gate_en;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stop_clk_arbiter #(.N_SRC(N)) i_stop_clk_arbiter (
        .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .osc_ready(osc_ready),
        .src_req(src_req), .src_frame_done(src_frame_done),
        .src_wake_frame(src_wake_frame), .osc_en(osc_en),
        .clk_gate_en(clk_gate_en), .sys_wake(sys_wake)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [N-1:0] gat, logic osc, logic wk);
        checks++;
        if (clk_gate_en !== gat || osc_en !== osc || sys_wake !== wk) begin
            errors++;
            $display("FAIL %s: gate=%b osc=%b wake=%b expected gate=%b osc=%b wake=%b",
                     req, clk_gate_en, osc_en, sys_wake, gat, osc, wk);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        chk("R1", '0, 1'b0, 1'b0);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1", '0, 1'b0, 1'b0);

        for (int m = 0; m < 32; m++) begin
            logic [N-1:0] msk, wk;
            msk = m[N-1:0];
            wk  = msk & N'((m * 7 + 3) % 32);
            stop_mode = 1'b1;
            src_req   = msk;
            osc_ready = 1'b0;
            tick();
            chk("R2", '0, msk != 0, 1'b0);
            src_frame_done = '1;                 // not active yet: R9
            src_wake_frame = '1;
            tick();
            chk("R9", '0, msk != 0, 1'b0);
            src_frame_done = '0;
            src_wake_frame = '0;
            osc_ready = 1'b1;
            tick();
            chk("R3_R4", msk, msk != 0, 1'b0);
            src_frame_done = msk;
            src_wake_frame = wk;
            src_req = '0;
            tick();
            chk("R5_R6", wk, wk != 0, wk != 0);
            src_frame_done = '0;
            src_wake_frame = '0;
            tick();
            chk("R6", wk, wk != 0, wk != 0);
            stop_mode = 1'b0;
            tick();
            chk("R7", '0, 1'b0, 1'b0);
            osc_ready = 1'b0;
        end

        // R8: withdraw one request while active, then the last one
        stop_mode = 1'b1;
        src_req = 5'b00011;
        tick();
        osc_ready = 1'b1;
        tick();
        chk("R8", 5'b00011, 1'b1, 1'b0);
        src_req = 5'b00001;
        tick();
        chk("R8", 5'b00001, 1'b1, 1'b0);
        src_req = '0;
        tick();
        chk("R8", '0, 1'b0, 1'b0);

        // R8: withdraw while waiting for ready
        osc_ready = 1'b0;
        src_req = 5'b10000;
        tick();
        chk("R8", '0, 1'b1, 1'b0);
        src_req = '0;
        tick();
        chk("R8", '0, 1'b0, 1'b0);

        // R5: one source finishes, the other keeps the oscillator on
        src_req = 5'b01100;
        osc_ready = 1'b1;
        tick();
        tick();
        chk("R5", 5'b01100, 1'b1, 1'b0);
        src_frame_done = 5'b00100;
        src_req = 5'b01000;
        tick();
        chk("R5", 5'b01000, 1'b1, 1'b0);
        src_frame_done = '0;
        stop_mode = 1'b0;
        tick();
        chk("R7", '0, 1'b0, 1'b0);

        // R7: requests outside stop are ignored
        src_req = '1;
        osc_ready = 1'b1;
        tick();
        tick();
        chk("R7", '0, 1'b0, 1'b0);
        src_req = '0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule